// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an asynchronous byte-wide static RAM of 64K words. It turns one host request, either a single-byte read or a single-byte write, into the pin sequence such a RAM expects. That sequence covers the address, an active-low and an active-high chip select, an active-low output enable, an active-low write enable, and a shared tri-state data bus with its own drive-enable output.

Every analogue timing limit of the RAM is turned into a whole number of clock cycles, rounded up. The inputs to that conversion are a clock-period parameter and a speed-grade parameter that selects the fast limits (55 ns cycle) or the slow limits (70 ns cycle). All pins leave the block straight from flip-flops.

A write is bracketed so that the address and both chip selects settle before the write strobe falls. The bus is driven only while the output enable is high, and it stays driven for one cycle after the strobe rises. After a read, the bus stays undriven for at least the RAM's output-float time before the next write may drive it. A read captures the bus once both the address-access time and the output-enable time have elapsed, and then pulses `done_o`.

Top module: `sram_bus_ctrl`

## Requirements
- R1: During and right after reset the pins are idle: `mem_cs1_n_o`=1, `mem_cs2_o`=0, `mem_oe_n_o`=1, `mem_we_n_o`=1, `mem_dq_oe_o`=0, `busy_o`=0, `done_o`=0.
- R2: A read is accepted on the first clock edge with `req_i`=1, `req_we_i`=0 and `busy_o`=0. On that edge, `mem_addr_o` takes the request address, `mem_cs1_n_o` goes to 0, `mem_cs2_o` goes to 1 and `mem_oe_n_o` goes to 0, while `mem_we_n_o` stays 1.
- R3: A read captures the bus into `rdata_o` on the edge AA cycles after acceptance, where AA is the larger of ceil(tAA/Tclk) and ceil(tOE/Tclk). `done_o` is high for exactly the one cycle after that edge, and `rdata_o` keeps its value until the next capture.
- R4: A write (`req_we_i`=1) asserts the address and both chip selects on its acceptance edge, with `mem_we_n_o` still 1. `mem_we_n_o` falls one edge later, and `mem_oe_n_o` stays 1 for the whole write.
- R5: While the write strobe is low and both selects are active, the window lasts at least ceil(tWP/Tclk) cycles. Selects and write data are held for at least ceil(tCW/Tclk) and ceil(tDW/Tclk) cycles respectively before `mem_we_n_o` rises.
- R6: After `mem_we_n_o` rises, the data drive, the chip selects and the address are held for one more cycle. On the next edge the drive and the selects are released and `done_o` pulses.
- R7: `mem_dq_oe_o` is never 1 while `mem_oe_n_o` is 0. After a read, the bus is not driven within ceil(tOHZ/Tclk) cycles (at least one) of the output enable going high.
- R8: Two consecutive acceptance edges are at least ceil(tRC/Tclk) cycles apart.
- R9: A request presented while `busy_o`=1 is ignored: no access starts and the RAM contents are not changed.
- R10: A read returns the byte most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, sampled while idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Word address of the request |
| req_wdata_i | input | 8 | Byte to write |
| busy_o | output | 1 | Access or recovery in progress; requests ignored |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Byte captured by the last read |
| mem_addr_o | output | 16 | RAM address pins |
| mem_cs1_n_o | output | 1 | Active-low chip select |
| mem_cs2_o | output | 1 | Active-high chip select |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_we_n_o | output | 1 | Active-low write enable |
| mem_dq | inout | 8 | Shared RAM data bus |
| mem_dq_oe_o | output | 1 | 1 while the controller drives `mem_dq` |

## Verification
With the defaults (8 ns clock, fast grade), a read's capture and `done_o` pulse are due 7 cycles after the acceptance edge. For a write, the strobe falls 1 cycle after acceptance, rises 6 cycles after it, and the release with `done_o` follows 7 cycles after acceptance. The bench counts clock edges from the first falling-edge sample at which `busy_o` is seen high, and compares each pin event against those counts at the falling edge. A RAM model in the bench returns corrupted data until enough cycles have elapsed to satisfy access time. It also counts the float interval after every read, so an early capture or a premature bus drive shows up as a wrong byte or a contention failure.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WSET,
      ST_WLOW,
      ST_WHOLD,
      ST_GAP
   } st_e;

   // nanoseconds to whole clock cycles, rounded up
   function automatic int ns2cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int AA_C   = 7,
   parameter int WL_C   = 5,
   parameter int RD_GAP = 3,
   parameter int WR_GAP = 1,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              req_we_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   output logic              acc_o,
   output logic              cap_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              drv_o,
   output logic              cs1_n_o,
   output logic              cs2_o,
   output logic              oe_n_o,
   output logic              we_n_o,
   output logic [ADDR_W-1:0] addr_o
);

   localparam logic [CNT_W-1:0] AA_L = CNT_W'(AA_C - 1);
   localparam logic [CNT_W-1:0] WL_L = CNT_W'(WL_C - 1);
   localparam logic [CNT_W-1:0] RG_L = CNT_W'(RD_GAP - 1);
   localparam logic [CNT_W-1:0] WG_L = CNT_W'(WR_GAP - 1);

   st_e              st;
   logic [CNT_W-1:0] cnt;
   logic             cnt_zero;

   assign cnt_zero = (cnt == '0);
   assign acc_o    = (st == ST_IDLE) && req_i;
   assign cap_o    = (st == ST_RD) && cnt_zero;
   assign busy_o   = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         addr_o  <= '0;
         cs1_n_o <= 1'b1;
         cs2_o   <= 1'b0;
         oe_n_o  <= 1'b1;
         we_n_o  <= 1'b1;
         drv_o   <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (req_i) begin
                  addr_o  <= req_addr_i;
                  cs1_n_o <= 1'b0;
                  cs2_o   <= 1'b1;
                  if (req_we_i) begin
                     drv_o <= 1'b1;
                     st    <= ST_WSET;
                  end else begin
                     oe_n_o <= 1'b0;
                     cnt    <= AA_L;
                     st     <= ST_RD;
                  end
               end
            end
            ST_RD: begin
               if (cnt_zero) begin
                  cs1_n_o <= 1'b1;
                  cs2_o   <= 1'b0;
                  oe_n_o  <= 1'b1;
                  done_o  <= 1'b1;
                  cnt     <= RG_L;
                  st      <= ST_GAP;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_WSET: begin
               we_n_o <= 1'b0;
               cnt    <= WL_L;
               st     <= ST_WLOW;
            end
            ST_WLOW: begin
               if (cnt_zero) begin
                  we_n_o <= 1'b1;
                  st     <= ST_WHOLD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_WHOLD: begin
               drv_o   <= 1'b0;
               cs1_n_o <= 1'b1;
               cs2_o   <= 1'b0;
               done_o  <= 1'b1;
               cnt     <= WG_L;
               st      <= ST_GAP;
            end
            ST_GAP: begin
               if (cnt_zero) st <= ST_IDLE;
               else          cnt <= cnt - 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R7: bus drive never overlaps an enabled RAM output
   a_r7_drive_needs_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
      drv_o |-> oe_n_o);

   // R4: output enable stays high while the write strobe is low
   a_r4_write_keeps_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n_o |-> oe_n_o);

   // R5: strobe low only inside a selected, driven window
   a_r5_we_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n_o |-> (!cs1_n_o && cs2_o && drv_o));

   // R6: address frozen while strobe low and one cycle after
   a_r6_addr_stable_write: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n_o |=> $stable(addr_o));

   // R6: drive and selects still present when the strobe rises
   a_r6_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n_o) |-> (drv_o && !cs1_n_o && cs2_o));

   // R2: output enable only with the chip selected and no write
   a_r2_read_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n_o |-> (!cs1_n_o && cs2_o && we_n_o));

   // R3: completion is a single-cycle pulse
   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9: no new address while an access is in flight
   a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && st != ST_GAP) |=> $stable(addr_o));

endmodule

// File: rtl/sram_ctrl_dq.sv
module sram_ctrl_dq #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              cap_i,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] wd_o,
   output logic [DATA_W-1:0] rdata_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_o    <= '0;
         rdata_o <= '0;
      end else begin
         if (acc_i) wd_o <= wdata_i;
         if (cap_i) rdata_o <= dq_i;
      end
   end

   // R3: read data only changes on a capture strobe
   a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_i |=> $stable(rdata_o));

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int CLK_NS     = 8,
   parameter bit FAST_GRADE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              req_we_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_cs1_n_o,
   output logic              mem_cs2_o,
   output logic              mem_oe_n_o,
   output logic              mem_we_n_o,
   inout  wire  [DATA_W-1:0] mem_dq,
   output logic              mem_dq_oe_o
);

   // speed-grade limits in ns
   localparam int T_RC  = FAST_GRADE ? 55 : 70;
   localparam int T_AA  = FAST_GRADE ? 55 : 70;
   localparam int T_OE  = FAST_GRADE ? 25 : 35;
   localparam int T_WP  = FAST_GRADE ? 40 : 50;
   localparam int T_CW  = FAST_GRADE ? 45 : 60;
   localparam int T_DW  = FAST_GRADE ? 25 : 30;
   localparam int T_OHZ = FAST_GRADE ? 20 : 25;

   // cycle counts
   localparam int RC_C   = ns2cyc(T_RC, CLK_NS);
   localparam int AA_C   = imax(imax(ns2cyc(T_AA, CLK_NS), ns2cyc(T_OE, CLK_NS)), 1);
   localparam int WP_C   = ns2cyc(T_WP, CLK_NS);
   localparam int CW_C   = ns2cyc(T_CW, CLK_NS);
   localparam int DW_C   = ns2cyc(T_DW, CLK_NS);
   localparam int HZ_C   = imax(ns2cyc(T_OHZ, CLK_NS), 1);
   localparam int WL_C   = imax(imax(WP_C, CW_C - 1), imax(DW_C - 1, 1));
   localparam int RD_GAP = imax(HZ_C, RC_C - AA_C);
   localparam int WR_GAP = imax(1, RC_C - (WL_C + 2));
   localparam int MAXC   = imax(imax(AA_C, WL_C), imax(RD_GAP, WR_GAP));
   localparam int CNT_W  = $clog2(MAXC + 1);

   generate
      if (CLK_NS < 1) begin : g_bad_clk
         $error("CLK_NS must be at least 1");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic              acc;
   logic              cap;
   logic              drv;
   logic [DATA_W-1:0] wd;

   sram_ctrl_seq #(
      .ADDR_W (ADDR_W),
      .AA_C   (AA_C),
      .WL_C   (WL_C),
      .RD_GAP (RD_GAP),
      .WR_GAP (WR_GAP),
      .CNT_W  (CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .req_we_i   (req_we_i),
      .req_addr_i (req_addr_i),
      .acc_o      (acc),
      .cap_o      (cap),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .drv_o      (drv),
      .cs1_n_o    (mem_cs1_n_o),
      .cs2_o      (mem_cs2_o),
      .oe_n_o     (mem_oe_n_o),
      .we_n_o     (mem_we_n_o),
      .addr_o     (mem_addr_o)
   );

   sram_ctrl_dq #(
      .DATA_W (DATA_W)
   ) u_dq (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_i   (acc),
      .wdata_i (req_wdata_i),
      .cap_i   (cap),
      .dq_i    (mem_dq),
      .wd_o    (wd),
      .rdata_o (rdata_o)
   );

   assign mem_dq      = drv ? wd : {DATA_W{1'bz}};
   assign mem_dq_oe_o = drv;

endmodule

// File: tb/sram_bus_ctrl_bench.sv
module sram_bus_ctrl_bench;

   localparam int CLK = 8;

   function automatic int cdiv(input int ns);
      return (ns + CLK - 1) / CLK;
   endfunction

   localparam int TAA_B = 55;
   localparam int RCB   = 7;   // ceil(55/8)
   localparam int AAB   = 7;   // ceil(max(55,25)/8)
   localparam int WPB   = 5;   // ceil(40/8)
   localparam int CWB   = 6;   // ceil(45/8)
   localparam int DWB   = 4;   // ceil(25/8)
   localparam int HZB   = 3;   // ceil(20/8)

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        req_we = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        busy, done;
   logic [7:0]  rdata;
   logic [15:0] mem_addr;
   logic        cs1_n, cs2, oe_n, we_n, dq_oe;
   wire  [7:0]  mem_dq;

   sram_bus_ctrl u_sram_bus_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req),
      .req_we_i    (req_we),
      .req_addr_i  (req_addr),
      .req_wdata_i (req_wdata),
      .busy_o      (busy),
      .done_o      (done),
      .rdata_o     (rdata),
      .mem_addr_o  (mem_addr),
      .mem_cs1_n_o (cs1_n),
      .mem_cs2_o   (cs2),
      .mem_oe_n_o  (oe_n),
      .mem_we_n_o  (we_n),
      .mem_dq      (mem_dq),
      .mem_dq_oe_o (dq_oe)
   );

   always #(CLK/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // ---------------- RAM model ----------------
   logic [7:0] mem [0:255];
   logic [7:0] shadow [0:255];
   int  age = 0;
   int  flt = 0;
   logic mem_rd, wr_act, wr_prev;
   logic [7:0] wr_lat;

   function automatic logic [7:0] init_val(input int i);
      return 8'(i) ^ 8'h5A;
   endfunction

   assign mem_rd = !cs1_n && cs2 && !oe_n && we_n;
   assign wr_act = !cs1_n && cs2 && !we_n;
   assign mem_dq = mem_rd ? (((age + 1) * CLK >= TAA_B) ? mem[mem_addr[7:0]]
                                                        : ~mem[mem_addr[7:0]])
                          : 8'hzz;

   always @(posedge clk) begin
      age <= mem_rd ? age + 1 : 0;
      if (mem_rd) flt <= HZB;
      else if (flt > 0) flt <= flt - 1;
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc >= 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         report();
         $finish;
      end
   end

   // ---------------- monitor ----------------
   logic [15:0] exp_addr = '0;
   int   t0 = -100, last_acc = -1000, t_rise = -100, wl = 0, acc_cnt = 0;
   bit   is_rd = 0;
   logic busy_q = 0, we_q = 1, done_q = 0;
   logic [7:0] last_rd = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         // model write storage at end of write overlap
         if (wr_act) wr_lat = mem_dq;
         if (wr_prev && !wr_act) mem[mem_addr[7:0]] = wr_lat;
         wr_prev = wr_act;

         if (busy && !busy_q) begin
            acc_cnt++;
            chk(cyc - last_acc >= RCB, "R8 accept spacing", cyc - last_acc, RCB);
            last_acc = cyc;
            t0 = cyc;
            is_rd = !oe_n;
            chk(mem_addr == exp_addr, "R2 address on accept", mem_addr, exp_addr);
            chk(!cs1_n && cs2, "R2 selects on accept", {cs1_n, cs2}, 2'b01);
            if (is_rd) chk(we_n, "R2 WE high in read", we_n, 1);
            else chk(we_n && oe_n && dq_oe, "R4 write setup", {we_n, oe_n, dq_oe}, 3'b111);
         end
         if (!we_n && we_q) chk(cyc == t0 + 1, "R4 WE fall cycle", cyc - t0, 1);
         if (!we_n) begin
            wl++;
            if (!oe_n) chk(0, "R4 OE low in write", oe_n, 1);
         end
         if (we_n && !we_q) begin
            chk(wl >= WPB, "R5 write pulse", wl, WPB);
            chk(cyc - t0 >= CWB, "R5 select to end", cyc - t0, CWB);
            chk(cyc - t0 >= DWB, "R5 data to end", cyc - t0, DWB);
            chk(dq_oe && !cs1_n && cs2, "R6 hold at WE rise", {dq_oe, cs1_n, cs2}, 3'b101);
            wl = 0;
            t_rise = cyc;
         end
         if (cyc == t_rise + 1)
            chk(!dq_oe && cs1_n && !cs2 && done && mem_addr == exp_addr,
                "R6 release after hold", {dq_oe, cs1_n, cs2, done}, 4'b0101);
         if (done && is_rd) chk(cyc == t0 + AAB, "R3 read latency", cyc - t0, AAB);
         if (done && done_q) chk(0, "R3 done pulse width", 2, 1);
         if (dq_oe && (mem_rd || flt > 0)) chk(0, "R7 bus contention", flt, 0);
         if (!done && rdata != last_rd) chk(0, "R3 rdata hold", rdata, last_rd);
         if (done) last_rd = rdata;
         busy_q = busy;
         we_q = we_n;
         done_q = done;
      end
   end

   // ---------------- stimulus ----------------
   task automatic wait_idle;
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic do_write(input logic [15:0] a, input logic [7:0] d);
      wait_idle();
      req = 1; req_we = 1; req_addr = a; req_wdata = d; exp_addr = a;
      shadow[a[7:0]] = d;
      @(negedge clk);
      req = 0;
      while (!done) @(negedge clk);
   endtask

   task automatic do_read(input logic [15:0] a);
      wait_idle();
      req = 1; req_we = 0; req_addr = a; exp_addr = a;
      @(negedge clk);
      req = 0;
      while (!done) @(negedge clk);
      chk(rdata == shadow[a[7:0]], "R10 read data", rdata, shadow[a[7:0]]);
   endtask

   logic [15:0] pool [0:15];

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 256; i++) begin
         mem[i] = init_val(i);
         shadow[i] = init_val(i);
      end
      for (int i = 0; i < 16; i++)
         pool[i] = {8'($urandom), 4'(i), 4'($urandom)};
      wr_prev = 0;

      repeat (3) @(negedge clk);
      chk(cs1_n && !cs2 && oe_n && we_n && !dq_oe && !busy && !done,
          "R1 reset pins", {cs1_n, cs2, oe_n, we_n, dq_oe, busy, done}, 7'b1011000);
      rst_n = 1;
      @(negedge clk);
      chk(cs1_n && !cs2 && oe_n && we_n && !dq_oe && !busy && !done,
          "R1 idle after reset", {cs1_n, cs2, oe_n, we_n, dq_oe, busy, done}, 7'b1011000);

      // directed cases
      do_read(pool[3]);                 // unwritten location
      do_write(pool[0], 8'hC3);
      do_read(pool[0]);
      do_write(pool[1], 8'h00);         // back-to-back writes
      do_write(pool[2], 8'hFF);
      do_read(pool[1]);
      do_write(pool[1], 8'h7E);         // read then write: bus turnaround
      do_read(pool[2]);
      do_read(pool[1]);

      // R9: request while busy is dropped
      begin
         int acc0;
         logic [7:0] keep;
         keep = shadow[pool[5][7:0]];
         acc0 = acc_cnt;
         wait_idle();
         req = 1; req_we = 1; req_addr = pool[4]; req_wdata = 8'h96;
         exp_addr = pool[4]; shadow[pool[4][7:0]] = 8'h96;
         @(negedge clk);
         req = 0;
         @(negedge clk);
         req = 1; req_we = 1; req_addr = pool[5]; req_wdata = ~keep;
         @(negedge clk);
         req = 0;
         while (!done) @(negedge clk);
         wait_idle();
         chk(acc_cnt == acc0 + 1, "R9 accepts during busy", acc_cnt - acc0, 1);
         do_read(pool[5]);
         chk(rdata == keep, "R9 ignored write left data", rdata, keep);
      end

      // constrained random mix
      for (int i = 0; i < 80; i++) begin
         int k;
         k = int'($urandom % 16);
         if ($urandom % 2 == 0) do_write(pool[k], 8'($urandom));
         else do_read(pool[k]);
      end
      for (int i = 0; i < 16; i++) do_read(pool[i]);

      repeat (10) @(negedge clk);
      report();
      $finish;
   end

endmodule